// File: doc/BRIEF.md
# Banked Register Complement and Compare-Skip Execute Unit

This block is the execute stage for a small slice of an 8-bit accumulator-style core. It takes 16-bit instruction words, one per instruction cycle. It understands two operations. The first is a bitwise complement of a data-memory byte, with the result sent either to the working register or back to the byte. The second compares a data-memory byte with the working register and, when the two are equal, drops the instruction fetched after it. Any other word runs as a one-cycle no-operation.

Each instruction cycle is four clock periods long, with one phase per period: decode, read, process and write. A 12-bit data address is formed in one of two ways. In access mode, addresses in the low half of the 8-bit field go to the bottom bank and addresses in the high half go to the top bank. In banked mode, a 4-bit bank register supplies the upper bits. The data memory sits outside the block and is reached through a combinational read port and a write strobe driven in the write phase.

The host program counter uses two outputs. `pc_inc` counts each consumed word, and `pc_skip` with `skip_words` reports a taken skip. The flag `nxt_two_word` tells the unit whether the word that follows the current one begins a two-word instruction.

Top module: `rf_exec_unit`

## Requirements
- R1: A word with bits [15:10] = 000111 is a complement. Bits [7:0] give the register field f, bit 9 gives the destination d and bit 8 gives the bank mode a. The result is the bitwise inverse of the addressed byte. With d=1, `dmem_we` is high in phase 3 with `dmem_wdata` equal to the result, and the byte holds the result afterwards.
- R2: A complement with d=0 loads the result into `wreg` at the end of phase 3 and keeps `dmem_we` low.
- R3: After a complement, `flag_n` equals result bit 7 and `flag_z` is 1 exactly when the result is 0x00. For example, 0x13 gives 0xEC with N=1 and Z=0.
- R4: With a=0, `dmem_addr` is 0x000+f when f < 0x80 and 0xF00+f when f >= 0x80. The bank register has no effect on it.
- R5: With a=1, `dmem_addr` is {bank register, f}. The bank register loads from `bsr_value` on a clock where `bsr_load` is high. It is sampled by the decode phase of the next instruction cycle.
- R6: A word with bits [15:9] = 0110001 is a compare, with a at bit 8 and f at bits [7:0]. It never writes memory and leaves `wreg`, `flag_n` and `flag_z` unchanged.
- R7: If the compared byte equals `wreg`, the unit does two things. In phase 3 of the compare, `pc_skip` is high for one clock with `skip_words`=1. The next valid word is then discarded as a no-operation cycle that writes nothing and changes no state, and the word after it executes normally.
- R8: If a compare is equal and `nxt_two_word` was high with it, `skip_words`=2 and the next two valid words are both discarded.
- R9: If the compared byte differs from `wreg`, `pc_skip` stays low, `skip_words` is 0, and the next word executes.
- R10: An unrecognised valid word runs one cycle with no memory write and no change to `wreg` or the flags.
- R11: `phase` counts 0,1,2,3 repeatedly, one step per clock. `pc_inc` is high in phase 3 of every cycle that consumed a valid word, including discarded ones. It is low in a cycle whose decode phase saw no valid word.
- R12: A synchronous reset sets `wreg`, the flags, the bank register and `phase` to zero and clears any pending skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word, sampled in phase 0 |
| instr_valid | input | 1 | Instruction word present, sampled in phase 0 |
| nxt_two_word | input | 1 | The following word starts a two-word instruction |
| bsr_load | input | 1 | Load the bank register |
| bsr_value | input | 4 | New bank register value |
| dmem_rdata | input | 8 | Data memory read data for `dmem_addr` |
| dmem_addr | output | 12 | Data memory address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 8 | Data memory write data |
| wreg | output | 8 | Working register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| phase | output | 2 | Current phase, 0 to 3 |
| pc_inc | output | 1 | One word consumed this cycle |
| pc_skip | output | 1 | Skip taken |
| skip_words | output | 2 | Number of words the skip discards |

## Verification
A wrong latched address or bank shows up on `dmem_addr` one clock after decode, in phase 1 of the same instruction cycle. A wrong result or destination shows up on `dmem_we` and `dmem_wdata`, or on `wreg` and the flags, at the end of phase 3. A lost or miscounted pending skip stays hidden until the following instruction cycle, where a discarded word wrongly writes memory or a word that should run is silently dropped. The bench therefore always runs one or two instructions after each compare and checks their write strobe and stored bytes.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    typedef enum logic [1:0] {
        PH_DEC  = 2'd0,
        PH_RD   = 2'd1,
        PH_PROC = 2'd2,
        PH_WR   = 2'd3
    } phase_t;

    typedef enum logic [2:0] {
        K_IDLE = 3'd0,
        K_NOP  = 3'd1,
        K_DISC = 3'd2,
        K_INV  = 3'd3,
        K_CMP  = 3'd4
    } kind_t;

    localparam logic [5:0] OPC_INV = 6'b000111;
    localparam logic [6:0] OPC_CMP = 7'b0110001;

endpackage

// File: rtl/rfx_decode.sv
module rfx_decode
    import rfx_pkg::*;
#(
    parameter int F_W = 8,
    localparam int IW = 16
) (
    input  logic [IW-1:0]  word,
    output kind_t          kind,
    output logic           dst_reg,
    output logic           bank_mode,
    output logic [F_W-1:0] fld
);
    always_comb begin
        fld       = word[F_W-1:0];
        bank_mode = word[8];
        dst_reg   = 1'b0;
        if (word[15:10] == OPC_INV) begin
            kind    = K_INV;
            dst_reg = word[9];
        end else if (word[15:9] == OPC_CMP) begin
            kind = K_CMP;
        end else begin
            kind = K_NOP;
        end
    end
endmodule

// File: rtl/rfx_bank_addr.sv
module rfx_bank_addr #(
    parameter int F_W   = 8,
    parameter int BSR_W = 4,
    localparam int AW   = F_W + BSR_W
) (
    input  logic [F_W-1:0]   fld,
    input  logic             bank_mode,
    input  logic [BSR_W-1:0] bank,
    output logic [AW-1:0]    addr
);
    logic [BSR_W-1:0] upper;

    always_comb begin
        if (bank_mode) upper = bank;
        else           upper = {BSR_W{fld[F_W-1]}};
        addr = {upper, fld};
    end
endmodule

// File: rtl/rfx_alu.sv
module rfx_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] inv,
    output logic              inv_neg,
    output logic              inv_zero,
    output logic              same
);
    logic [DATA_W:0] diff;

    always_comb begin
        inv      = ~opnd;
        inv_neg  = inv[DATA_W-1];
        inv_zero = (inv == '0);
        diff     = {1'b0, opnd} - {1'b0, acc};
        same     = (diff == '0);
    end
endmodule

// File: rtl/rf_exec_unit.sv
module rf_exec_unit
    import rfx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int F_W    = 8,
    parameter int BSR_W  = 4,
    localparam int ADDR_W = F_W + BSR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       instr,
    input  logic              instr_valid,
    input  logic              nxt_two_word,
    input  logic              bsr_load,
    input  logic [BSR_W-1:0]  bsr_value,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic              dmem_we,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic [DATA_W-1:0] wreg,
    output logic              flag_n,
    output logic              flag_z,
    output logic [1:0]        phase,
    output logic              pc_inc,
    output logic              pc_skip,
    output logic [1:0]        skip_words
);
    typedef struct packed {
        phase_t              ph;
        kind_t               kind;
        logic                dst;
        logic [ADDR_W-1:0]   addr;
        logic                two;
        logic [DATA_W-1:0]   opnd;
        logic [DATA_W-1:0]   res;
        logic                rn;
        logic                rz;
        logic                eq;
        logic [DATA_W-1:0]   w;
        logic                n;
        logic                z;
        logic [BSR_W-1:0]    bank;
        logic [1:0]          pend;
    } st_t;

    st_t st_d, st_q;

    kind_t             dec_kind;
    logic              dec_dst;
    logic              dec_mode;
    logic [F_W-1:0]    dec_fld;
    logic [ADDR_W-1:0] gen_addr;
    logic [DATA_W-1:0] alu_inv;
    logic              alu_neg;
    logic              alu_zero;
    logic              alu_same;

    rfx_decode #(.F_W(F_W)) u_dec (
        .word      (instr),
        .kind      (dec_kind),
        .dst_reg   (dec_dst),
        .bank_mode (dec_mode),
        .fld       (dec_fld)
    );

    rfx_bank_addr #(.F_W(F_W), .BSR_W(BSR_W)) u_addr (
        .fld       (dec_fld),
        .bank_mode (dec_mode),
        .bank      (st_q.bank),
        .addr      (gen_addr)
    );

    rfx_alu #(.DATA_W(DATA_W)) u_alu (
        .opnd     (st_q.opnd),
        .acc      (st_q.w),
        .inv      (alu_inv),
        .inv_neg  (alu_neg),
        .inv_zero (alu_zero),
        .same     (alu_same)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ph = phase_t'(st_q.ph + 2'd1);
        if (bsr_load) st_d.bank = bsr_value;
        unique case (st_q.ph)
            PH_DEC: begin
                if (!instr_valid) begin
                    st_d.kind = K_IDLE;
                end else if (st_q.pend != 2'd0) begin
                    st_d.kind = K_DISC;
                    st_d.pend = st_q.pend - 2'd1;
                end else begin
                    st_d.kind = dec_kind;
                    st_d.dst  = dec_dst;
                    st_d.addr = gen_addr;
                    st_d.two  = nxt_two_word;
                end
            end
            PH_RD: begin
                st_d.opnd = dmem_rdata;
            end
            PH_PROC: begin
                st_d.res = alu_inv;
                st_d.rn  = alu_neg;
                st_d.rz  = alu_zero;
                st_d.eq  = alu_same;
            end
            PH_WR: begin
                if (st_q.kind == K_INV) begin
                    st_d.n = st_q.rn;
                    st_d.z = st_q.rz;
                    if (!st_q.dst) st_d.w = st_q.res;
                end
                if (st_q.kind == K_CMP && st_q.eq) begin
                    st_d.pend = st_q.two ? 2'd2 : 2'd1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    logic in_wr;
    assign in_wr      = (st_q.ph == PH_WR);
    assign dmem_addr  = st_q.addr;
    assign dmem_we    = in_wr && st_q.kind == K_INV && st_q.dst;
    assign dmem_wdata = st_q.res;
    assign wreg       = st_q.w;
    assign flag_n     = st_q.n;
    assign flag_z     = st_q.z;
    assign phase      = st_q.ph;
    assign pc_inc     = in_wr && st_q.kind != K_IDLE;
    assign pc_skip    = in_wr && st_q.kind == K_CMP && st_q.eq;
    assign skip_words = pc_skip ? (st_q.two ? 2'd2 : 2'd1) : 2'd0;

    p_phase_wrap_r11: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd3 |=> phase == 2'd0);

    p_skip_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        pc_skip |=> !pc_skip);

    p_skip_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        pc_skip |-> !dmem_we);

    p_cmp_keeps_state_r6: assert property (@(posedge clk) disable iff (rst)
        (in_wr && st_q.kind == K_CMP) |=> $stable({wreg, flag_n, flag_z}));

    p_disc_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.kind == K_DISC) |-> !dmem_we);

    p_write_counts_r11: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> pc_inc);

    p_zero_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (in_wr && st_q.kind == K_INV) |=> (flag_z == ($past(dmem_wdata) == '0)));

    p_words_r8: assert property (@(posedge clk) disable iff (rst)
        (skip_words != 2'd0) |-> pc_skip);
endmodule

// File: tb/rf_exec_unit_bench.sv
module rf_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = '0;
    logic        instr_valid = 1'b0;
    logic        nxt_two_word = 1'b0;
    logic        bsr_load = 1'b0;
    logic [3:0]  bsr_value = '0;
    logic [7:0]  dmem_rdata;
    logic [11:0] dmem_addr;
    logic        dmem_we;
    logic [7:0]  dmem_wdata;
    logic [7:0]  wreg;
    logic        flag_n, flag_z;
    logic [1:0]  phase;
    logic        pc_inc, pc_skip;
    logic [1:0]  skip_words;

    logic [7:0] mem [0:4095];
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rf_exec_unit u_rf_exec_unit (
        .clk(clk), .rst(rst), .instr(instr), .instr_valid(instr_valid),
        .nxt_two_word(nxt_two_word), .bsr_load(bsr_load), .bsr_value(bsr_value),
        .dmem_rdata(dmem_rdata), .dmem_addr(dmem_addr), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .wreg(wreg), .flag_n(flag_n), .flag_z(flag_z),
        .phase(phase), .pc_inc(pc_inc), .pc_skip(pc_skip), .skip_words(skip_words)
    );

    assign dmem_rdata = mem[dmem_addr];
    always @(posedge clk) if (dmem_we) mem[dmem_addr] <= dmem_wdata;

    logic [11:0] s_addr;
    logic [1:0]  s_ph1, s_ph3;
    logic        s_we, s_inc, s_skip;
    logic [7:0]  s_wd;
    logic [1:0]  s_sw;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_cycle(input logic [15:0] ins, input logic vld, input logic two,
                            input logic bl, input logic [3:0] bv);
        instr = ins; instr_valid = vld; nxt_two_word = two;
        bsr_load = bl; bsr_value = bv;
        @(negedge clk);
        instr_valid = 1'b0; bsr_load = 1'b0; nxt_two_word = 1'b0;
        s_addr = dmem_addr; s_ph1 = phase;
        @(negedge clk);
        @(negedge clk);
        s_ph3 = phase; s_we = dmem_we; s_wd = dmem_wdata;
        s_inc = pc_inc; s_skip = pc_skip; s_sw = skip_words;
        @(negedge clk);
    endtask

    // instr, bank, mem value, expected address, expected result
    localparam logic [47:0] VEC [6] = '{
        {16'h1E13, 4'h5, 8'h13, 12'h013, 8'hEC},
        {16'h1C85, 4'h5, 8'hFF, 12'hF85, 8'h00},
        {16'h1F7F, 4'hA, 8'h80, 12'hA7F, 8'h7F},
        {16'h1D80, 4'h3, 8'h5A, 12'h380, 8'hA5},
        {16'h1E7F, 4'hC, 8'h00, 12'h07F, 8'hFF},
        {16'h1CFF, 4'h2, 8'h01, 12'hFFF, 8'hFE}
    };

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] ins;
        logic [3:0]  bs;
        logic [7:0]  mv, er, wprev;
        logic [11:0] ea;
        for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R12 wreg after reset", wreg, 8'h00);
        chk("R12 flags after reset", {flag_n, flag_z}, 2'b00);
        chk("R12 phase after reset", phase, 2'd0);

        do_cycle(16'h1E13, 1'b0, 1'b0, 1'b0, 4'h0);
        chk("R11 idle cycle no pc_inc", s_inc, 1'b0);
        chk("R11 idle cycle no write", s_we, 1'b0);

        for (int i = 0; i < 6; i++) begin
            {ins, bs, mv, ea, er} = VEC[i];
            do_cycle(16'h0000, 1'b0, 1'b0, 1'b1, bs);
            mem[ea] = mv;
            wprev = wreg;
            do_cycle(ins, 1'b1, 1'b0, 1'b0, 4'h0);
            if (ins[8]) chk("R5 banked address", s_addr, ea);
            else        chk("R4 access address", s_addr, ea);
            chk("R11 phase sequence", {s_ph1, s_ph3}, {2'd1, 2'd3});
            chk("R11 pc_inc on word", s_inc, 1'b1);
            chk("R3 flags", {flag_n, flag_z}, {er[7], er == 8'h00});
            if (ins[9]) begin
                chk("R1 write strobe", s_we, 1'b1);
                chk("R1 write data", s_wd, er);
                chk("R1 stored byte", mem[ea], er);
                chk("R1 wreg kept", wreg, wprev);
            end else begin
                chk("R2 no write", s_we, 1'b0);
                chk("R2 wreg result", wreg, er);
            end
        end

        // equal compare, single-word skip
        mem[12'h020] = 8'h3C;
        do_cycle(16'h1C20, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R2 wreg preset", wreg, 8'hC3);
        mem[12'h021] = 8'hC3;
        do_cycle(16'h6221, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R6 compare no write", s_we, 1'b0);
        chk("R6 compare keeps state", {wreg, flag_n, flag_z}, {8'hC3, 1'b1, 1'b0});
        chk("R7 skip pulse", {s_skip, s_sw}, {1'b1, 2'd1});
        do_cycle(16'h1E21, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R7 discarded no write", s_we, 1'b0);
        chk("R7 discarded counts word", s_inc, 1'b1);
        chk("R7 discarded byte kept", mem[12'h021], 8'hC3);
        chk("R7 discarded state kept", {wreg, flag_n, flag_z}, {8'hC3, 1'b1, 1'b0});
        do_cycle(16'h1E21, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R7 next word executes", {s_we, mem[12'h021]}, {1'b1, 8'h3C});

        // equal compare, two-word skip, banked
        do_cycle(16'h0000, 1'b0, 1'b0, 1'b1, 4'h7);
        mem[12'h744] = 8'hC3;
        mem[12'h045] = 8'h11;
        do_cycle(16'h6344, 1'b1, 1'b1, 1'b0, 4'h0);
        chk("R5 compare banked address", s_addr, 12'h744);
        chk("R8 skip two words", {s_skip, s_sw}, {1'b1, 2'd2});
        do_cycle(16'h1E45, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R8 first discarded", {s_we, s_inc}, {1'b0, 1'b1});
        do_cycle(16'h1E45, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R8 second discarded", {s_we, s_inc}, {1'b0, 1'b1});
        chk("R8 byte kept", mem[12'h045], 8'h11);
        do_cycle(16'h1E45, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R8 third word executes", {s_we, mem[12'h045]}, {1'b1, 8'hEE});

        // unequal compare
        mem[12'h030] = 8'hC4;
        mem[12'h031] = 8'h0F;
        do_cycle(16'h6230, 1'b1, 1'b1, 1'b0, 4'h0);
        chk("R9 no skip", {s_skip, s_sw}, {1'b0, 2'd0});
        do_cycle(16'h1E31, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R9 next executes", {s_we, mem[12'h031]}, {1'b1, 8'hF0});

        // unrecognised word
        do_cycle(16'hFFFF, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R10 no write", s_we, 1'b0);
        chk("R10 pc_inc", s_inc, 1'b1);
        chk("R10 state kept", {wreg, flag_n, flag_z}, {8'hC3, 1'b1, 1'b0});

        // reset clears pending skip and bank
        mem[12'h050] = 8'hC3;
        do_cycle(16'h6250, 1'b1, 1'b0, 1'b1, 4'h9);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R12 wreg cleared", wreg, 8'h00);
        chk("R12 flags cleared", {flag_n, flag_z}, 2'b00);
        chk("R12 phase cleared", phase, 2'd0);
        mem[12'h052] = 8'h55;
        do_cycle(16'h1F52, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R12 bank cleared", s_addr, 12'h052);
        chk("R12 pending skip cleared", {s_we, mem[12'h052]}, {1'b1, 8'hAA});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule